// File: doc/BRIEF.md
# Parallel Configuration Master

This block configures a programmable target device through its byte-wide slave configuration port. It drives the program, chip-select, write and configuration clock lines and an 8-bit data bus. It samples the target's init, busy and done status lines. A host starts an operation with a one-cycle strobe and is told when it ends by a one-cycle completion pulse, which carries a failure flag.

A load operation has four phases. The block first pulses program, then waits for the target to leave initialisation. It then raises write and chip select and streams bytes taken from a valid/ready input, giving one configuration clock rising edge per byte. When stall checking is enabled, a busy target makes the block repeat the clock edge on the same byte. After the last byte the block drops chip select and then write, and keeps clocking until the target reports done. A readback operation selects the target in read direction and clocks out a requested number of bytes, each of which appears on a valid-qualified output. Each wait on the target is bounded by a cycle-count timeout. The configuration clock rate is derived from the system clock and is capped at 50 MHz.

Top module: `cfg_par_master`

## Requirements
- R1: After reset, cfg_clk is 1 and cfg_prog, cfg_sel, cfg_wr, cfg_dir, in_ready, out_valid and op_done are all 0.
- R2: start_load raises cfg_prog and then lowers it. cfg_sel and cfg_wr stay 0 while cfg_prog is 1, and cfg_sel is not raised until cfg_init and cfg_busy are both 0.
- R3: If cfg_init stays 1 for TIMEOUT_CYC cycles after the program pulse, the block ends with op_done=1 and op_fail=1. cfg_sel is never raised in that case.
- R4: During a load, cfg_wr and cfg_sel are both 1 before the first rising edge of cfg_clk. Each byte accepted on in_data (when in_valid and in_ready are both 1) produces exactly one rising edge, with that byte stable on cfg_dout, in acceptance order. The byte marked by in_last is the final one.
- R5: With busy_chk_en=1, a cfg_busy of 1 seen after a byte's rising edge makes the block issue further rising edges with the same byte held on cfg_dout until cfg_busy is 0. With busy_chk_en=0, cfg_busy has no effect during the data phase.
- R6: At the end of the data phase, cfg_sel falls while cfg_wr is still 1, and cfg_wr falls afterwards.
- R7: After the data phase the block pulses cfg_clk until cfg_done is 1 and then gives a one-cycle op_done with op_fail=0. If cfg_done is already 1, no further edge is issued.
- R8: If cfg_done does not rise within TIMEOUT_CYC cycles of the done wait, the block ends with op_done=1 and op_fail=1.
- R9: start_read with read_len=N>0 raises cfg_sel while cfg_clk is 1 and produces N low/high cfg_clk pulses. After each rising edge it presents the sampled cfg_din on out_data with a one-cycle out_valid, in order.
- R10: At the end of a readback, cfg_sel falls first. Exactly one more rising edge of cfg_clk follows before op_done, and op_fail=0.
- R11: cfg_dir is 1 (read) only during a readback and 0 otherwise. While cfg_dir is 1, cfg_wr and in_ready are 0.
- R12: Each low phase and each high phase of cfg_clk lasts at least ceil(SYS_CLK_HZ / (2*min(CFG_CLK_HZ, 50 MHz))) system cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_load | input | 1 | Strobe: begin a load operation |
| start_read | input | 1 | Strobe: begin a readback operation |
| read_len | input | LEN_W | Number of bytes to read back |
| busy_chk_en | input | 1 | Enable busy-driven clock stretching during load |
| in_data | input | DATA_W | Load byte |
| in_valid | input | 1 | Load byte valid |
| in_last | input | 1 | Marks the final load byte |
| in_ready | output | 1 | Block accepts a load byte |
| out_data | output | DATA_W | Readback byte |
| out_valid | output | 1 | Readback byte valid (one cycle) |
| op_done | output | 1 | One-cycle operation completion pulse |
| op_fail | output | 1 | Operation failed (valid with op_done) |
| cfg_prog | output | 1 | Program request to target, active high |
| cfg_sel | output | 1 | Chip select to target, active high |
| cfg_wr | output | 1 | Write strobe to target, active high |
| cfg_clk | output | 1 | Configuration clock, idles high |
| cfg_dir | output | 1 | Data bus direction: 1 read, 0 write |
| cfg_dout | output | DATA_W | Data bus value driven to the target |
| cfg_din | input | DATA_W | Data bus value read from the target |
| cfg_init | input | 1 | Target still initialising, active high |
| cfg_busy | input | 1 | Target busy, active high |
| cfg_done | input | 1 | Target configuration complete |

## Verification
The hardest case to reach is the busy stall on one chosen byte in the middle of a stream, where the stall must repeat the same byte for a controlled number of edges. The bench contains a reactive target model that raises cfg_busy right after the rising edge of a randomly chosen byte index and keeps it high for a random number of further edges. The expected edge sequence is rebuilt with that byte repeated, and the same stimulus is replayed with stall checking disabled. The done and init timeouts are reached by telling the model never to release the relevant status line.

// File: rtl/cfg_par_pkg.sv
package cfg_par_pkg;

    localparam int CFG_MAX_HZ = 50_000_000;

    typedef enum logic [4:0] {
        S_IDLE,
        S_PROG,
        S_WAIT_INIT,
        S_ARM_WR,
        S_ARM_SEL,
        S_LD_FETCH,
        S_LD_LOW,
        S_LD_HIGH,
        S_LD_CHK,
        S_ST_LOW,
        S_END_SEL,
        S_END_WR,
        S_DN_CHK,
        S_DN_LOW,
        S_RD_SEL,
        S_RD_LOW,
        S_RD_HIGH,
        S_RD_SAMP,
        S_RD_END,
        S_RD_XLOW,
        S_RD_XHIGH,
        S_OK,
        S_FAIL
    } cfg_state_e;

    typedef struct packed {
        logic prog;
        logic sel;
        logic wr;
        logic clk;
        logic dir;
    } cfg_pins_t;

    localparam cfg_pins_t PINS_IDLE = '{prog: 1'b0, sel: 1'b0, wr: 1'b0, clk: 1'b1, dir: 1'b0};

    // System cycles per configuration clock half period, capped at the target maximum rate.
    function automatic int half_period_div(int sys_hz, int cfg_hz);
        int eff;
        int d;
        eff = (cfg_hz > CFG_MAX_HZ) ? CFG_MAX_HZ : cfg_hz;
        if (eff < 1) eff = 1;
        d = (sys_hz + 2 * eff - 1) / (2 * eff);
        return (d < 1) ? 1 : d;
    endfunction

    // States in which the block waits on the target and the timeout runs.
    function automatic logic is_wait_state(cfg_state_e s);
        return s inside {S_WAIT_INIT, S_LD_CHK, S_ST_LOW, S_DN_CHK, S_DN_LOW};
    endfunction

endpackage

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_full
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (cnt == TOP) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = (cnt == TOP);

            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R12
        end
    endgenerate
endmodule

// File: rtl/cfg_wait_timer.sv
module cfg_wait_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LIM = W'(LIMIT);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != LIM) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LIM);

    AST_TIMER_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIM); // R3
endmodule

// File: rtl/cfg_par_master.sv
module cfg_par_master
    import cfg_par_pkg::*;
#(
    parameter int SYS_CLK_HZ  = 100_000_000,
    parameter int CFG_CLK_HZ  = 25_000_000,
    parameter int TIMEOUT_CYC = 1_000_000,
    parameter int LEN_W       = 16,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_load,
    input  logic              start_read,
    input  logic [LEN_W-1:0]  read_len,
    input  logic              busy_chk_en,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_last,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              op_done,
    output logic              op_fail,
    output logic              cfg_prog,
    output logic              cfg_sel,
    output logic              cfg_wr,
    output logic              cfg_clk,
    output logic              cfg_dir,
    output logic [DATA_W-1:0] cfg_dout,
    input  logic [DATA_W-1:0] cfg_din,
    input  logic              cfg_init,
    input  logic              cfg_busy,
    input  logic              cfg_done
);
    localparam int HALF_DIV = half_period_div(SYS_CLK_HZ, CFG_CLK_HZ);

    cfg_state_e        st;
    cfg_pins_t         pins;
    logic [DATA_W-1:0] dout_q;
    logic              last_q;
    logic [LEN_W-1:0]  rd_left;
    logic              tick;
    logic              expired;
    logic              wait_run;

    cfg_tick_gen #(.HALF_DIV(HALF_DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    assign wait_run = is_wait_state(st);

    cfg_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (wait_run),
        .expired (expired)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            pins      <= PINS_IDLE;
            dout_q    <= '0;
            last_q    <= 1'b0;
            rd_left   <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (start_load) begin
                        pins.prog <= 1'b1;
                        st        <= S_PROG;
                    end else if (start_read) begin
                        if (read_len == '0) begin
                            st <= S_OK;
                        end else begin
                            rd_left  <= read_len;
                            pins.dir <= 1'b1;
                            st       <= S_RD_SEL;
                        end
                    end
                end
                S_PROG: if (tick) begin
                    pins.prog <= 1'b0;
                    st        <= S_WAIT_INIT;
                end
                S_WAIT_INIT: begin
                    if (!cfg_init && !cfg_busy) begin
                        st <= S_ARM_WR;
                    end else if (tick && expired) begin
                        st <= S_FAIL;
                    end
                end
                S_ARM_WR: if (tick) begin
                    pins.wr <= 1'b1;
                    st      <= S_ARM_SEL;
                end
                S_ARM_SEL: if (tick) begin
                    pins.sel <= 1'b1;
                    st       <= S_LD_FETCH;
                end
                S_LD_FETCH: if (in_valid) begin
                    dout_q <= in_data;
                    last_q <= in_last;
                    st     <= S_LD_LOW;
                end
                S_LD_LOW: if (tick) begin
                    pins.clk <= 1'b0;
                    st       <= S_LD_HIGH;
                end
                S_LD_HIGH: if (tick) begin
                    pins.clk <= 1'b1;
                    st       <= S_LD_CHK;
                end
                S_LD_CHK: if (tick) begin
                    if (busy_chk_en && cfg_busy) begin
                        if (expired) begin
                            st <= S_FAIL;
                        end else begin
                            pins.clk <= 1'b0;
                            st       <= S_ST_LOW;
                        end
                    end else if (last_q) begin
                        st <= S_END_SEL;
                    end else begin
                        st <= S_LD_FETCH;
                    end
                end
                S_ST_LOW: if (tick) begin
                    pins.clk <= 1'b1;
                    st       <= S_LD_CHK;
                end
                S_END_SEL: if (tick) begin
                    pins.sel <= 1'b0;
                    st       <= S_END_WR;
                end
                S_END_WR: if (tick) begin
                    pins.wr <= 1'b0;
                    st      <= S_DN_CHK;
                end
                S_DN_CHK: begin
                    if (cfg_done) begin
                        st <= S_OK;
                    end else if (tick) begin
                        if (expired) begin
                            st <= S_FAIL;
                        end else begin
                            pins.clk <= 1'b0;
                            st       <= S_DN_LOW;
                        end
                    end
                end
                S_DN_LOW: if (tick) begin
                    pins.clk <= 1'b1;
                    st       <= S_DN_CHK;
                end
                S_RD_SEL: if (tick) begin
                    pins.sel <= 1'b1;
                    st       <= S_RD_LOW;
                end
                S_RD_LOW: if (tick) begin
                    pins.clk <= 1'b0;
                    st       <= S_RD_HIGH;
                end
                S_RD_HIGH: if (tick) begin
                    pins.clk <= 1'b1;
                    st       <= S_RD_SAMP;
                end
                S_RD_SAMP: begin
                    out_data  <= cfg_din;
                    out_valid <= 1'b1;
                    rd_left   <= rd_left - 1'b1;
                    st        <= (rd_left == LEN_W'(1)) ? S_RD_END : S_RD_LOW;
                end
                S_RD_END: if (tick) begin
                    pins.sel <= 1'b0;
                    st       <= S_RD_XLOW;
                end
                S_RD_XLOW: if (tick) begin
                    pins.clk <= 1'b0;
                    st       <= S_RD_XHIGH;
                end
                S_RD_XHIGH: if (tick) begin
                    pins.clk <= 1'b1;
                    st       <= S_OK;
                end
                S_OK, S_FAIL: begin
                    pins <= PINS_IDLE;
                    st   <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign in_ready = (st == S_LD_FETCH);
    assign op_done  = (st == S_OK) || (st == S_FAIL);
    assign op_fail  = (st == S_FAIL);
    assign cfg_prog = pins.prog;
    assign cfg_sel  = pins.sel;
    assign cfg_wr   = pins.wr;
    assign cfg_clk  = pins.clk;
    assign cfg_dir  = pins.dir;
    assign cfg_dout = dout_q;

    AST_PROG_ISOLATED: assert property (@(posedge clk) disable iff (rst)
        cfg_prog |-> (!cfg_sel && !cfg_wr)); // R2
    AST_SEL_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && !cfg_dir) |-> cfg_wr); // R6
    AST_WR_AFTER_SEL: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_wr) |-> !cfg_sel); // R6
    AST_CLK_PACED: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_clk) |-> $past(tick)); // R12
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        ($rose(cfg_clk) && cfg_sel && cfg_wr) |-> $stable(cfg_dout)); // R4
    AST_READ_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        cfg_dir |-> (!cfg_wr && !in_ready)); // R11
    AST_RD_VALID_IN_READ: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> cfg_dir); // R9
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done); // R7
    AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        op_fail |-> op_done); // R8
endmodule

// File: tb/test_cfg_par_master.sv
module test_cfg_par_master;
    localparam int TMO = 600;
    localparam int HALF = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_load = 1'b0, start_read = 1'b0, busy_chk_en = 1'b0;
    logic [15:0] read_len = '0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0, in_last = 1'b0;
    logic       in_ready, out_valid, op_done, op_fail;
    logic [7:0] out_data, cfg_dout;
    logic [7:0] cfg_din = '0;
    logic       cfg_prog, cfg_sel, cfg_wr, cfg_clk, cfg_dir;
    logic       cfg_init = 1'b1, cfg_busy = 1'b0, cfg_done = 1'b0;

    always #5 clk = ~clk;

    cfg_par_master #(
        .SYS_CLK_HZ(100_000_000), .CFG_CLK_HZ(25_000_000), .TIMEOUT_CYC(TMO),
        .LEN_W(16), .DATA_W(8)
    ) i_cfg_par_master (
        .clk(clk), .rst(rst), .start_load(start_load), .start_read(start_read),
        .read_len(read_len), .busy_chk_en(busy_chk_en), .in_data(in_data),
        .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .op_done(op_done), .op_fail(op_fail),
        .cfg_prog(cfg_prog), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_clk(cfg_clk),
        .cfg_dir(cfg_dir), .cfg_dout(cfg_dout), .cfg_din(cfg_din), .cfg_init(cfg_init),
        .cfg_busy(cfg_busy), .cfg_done(cfg_done)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_pat(input int k);
        return 8'((k * 29 + 90) & 255);
    endfunction

    // target model controls and observations
    int  init_delay = 0, stall_at = -1, stall_len = 0, done_after = 0;
    bit  hold_init = 0, load_act = 0, rd_act = 0;
    logic [7:0] rec [256];
    logic [7:0] rd_buf [64];
    int  ecnt, pre_edges, post_edges, scnt, init_cnt, rcnt, rd_edges, xedges, rd_got;
    int  sel_init_viol, dir_viol, order_viol, sel_clk_viol, rd_viol, sel_any, prog_seen;
    int  phase_len = 0, min_phase = 1000;
    bit  data_seen;
    logic prev_clk = 1'b1, prev_sel = 1'b0;

    initial begin : target_model
        forever begin
            @(negedge clk);
            if (!rst) begin
                phase_len++;
                if (cfg_clk != prev_clk) begin
                    if (phase_len < min_phase) min_phase = phase_len;
                    phase_len = 0;
                end
                if (load_act) begin
                    if (cfg_prog) begin
                        prog_seen++;
                        cfg_init = 1'b1;
                        init_cnt = 0;
                    end else if (cfg_init && !hold_init && prog_seen > 0) begin
                        init_cnt++;
                        if (init_cnt >= init_delay) cfg_init = 1'b0;
                    end
                    if (cfg_sel) sel_any++;
                    if (cfg_sel && cfg_init) sel_init_viol++;
                    if (cfg_dir) dir_viol++;
                    if (prev_sel && !cfg_sel && !cfg_wr) order_viol++;
                    if (cfg_clk && !prev_clk) begin
                        if (cfg_sel && cfg_wr) begin
                            if (ecnt < 256) rec[ecnt] = cfg_dout;
                            ecnt++;
                            data_seen = 1;
                            if (cfg_busy) begin
                                scnt++;
                                if (scnt >= stall_len) cfg_busy = 1'b0;
                            end else if (ecnt - 1 == stall_at && stall_len > 0) begin
                                cfg_busy = 1'b1;
                                scnt = 0;
                            end
                        end else if (!data_seen) begin
                            pre_edges++;
                        end else begin
                            post_edges++;
                        end
                    end
                    if (!cfg_sel) cfg_busy = 1'b0;
                    if (data_seen && !cfg_sel && !cfg_wr && !cfg_done &&
                        done_after >= 0 && post_edges >= done_after)
                        cfg_done = 1'b1;
                end
                if (rd_act) begin
                    if (cfg_sel && !prev_sel && !cfg_clk) sel_clk_viol++;
                    if (cfg_sel && !cfg_dir) rd_viol++;
                    if (in_ready || cfg_wr) rd_viol++;
                    if (!cfg_clk && prev_clk && cfg_sel) begin
                        cfg_din = rd_pat(rcnt);
                        rcnt++;
                    end
                    if (cfg_clk && !prev_clk) begin
                        if (cfg_sel) rd_edges++;
                        else if (cfg_dir) xedges++;
                    end
                    if (out_valid) begin
                        if (rd_got < 64) rd_buf[rd_got] = out_data;
                        rd_got++;
                    end
                end
            end
            prev_clk = cfg_clk;
            prev_sel = cfg_sel;
        end
    end

    task automatic wait_result(output bit fl, output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!op_done && cyc < 20000);
        fl = op_fail;
        if (!op_done) check(0, "R7 op_done never seen", 0, 1);
    endtask

    task automatic run_load(input int n, input bit en, input int st_at, input int st_len,
                            input int dn_after, input bit hinit, input int idelay,
                            input bit exp_fail);
        logic [7:0] bytes [64];
        bit fl;
        int cyc;
        int k;
        int bad;
        for (int i = 0; i < n; i++) bytes[i] = 8'($urandom);
        @(posedge clk);
        ecnt = 0; pre_edges = 0; post_edges = 0; scnt = 0; init_cnt = 0;
        sel_init_viol = 0; dir_viol = 0; order_viol = 0; sel_any = 0; prog_seen = 0;
        data_seen = 0; cfg_done = 1'b0; cfg_busy = 1'b0; cfg_init = 1'b1;
        hold_init = hinit; init_delay = idelay; stall_at = st_at; stall_len = st_len;
        done_after = dn_after; load_act = 1;
        @(negedge clk);
        start_load = 1'b1;
        busy_chk_en = en;
        @(negedge clk);
        start_load = 1'b0;
        fork
            begin : feeder
                for (int i = 0; i < n; i++) begin
                    int g;
                    in_data = bytes[i];
                    in_last = (i == n - 1);
                    in_valid = 1'b1;
                    g = 0;
                    forever begin
                        if (in_ready || g > 20000) begin
                            @(negedge clk);
                            break;
                        end
                        @(negedge clk);
                        g++;
                    end
                    in_valid = 1'b0;
                    in_last = 1'b0;
                    repeat ($urandom % 3) @(negedge clk);
                end
            end
            begin : result
                wait_result(fl, cyc);
            end
        join
        check(fl == exp_fail, exp_fail ? "R8/R3 op_fail" : "R7 op_fail", fl, exp_fail);
        check(prog_seen > 0, "R2 program pulse", prog_seen, 1);
        check(sel_init_viol == 0, "R2 sel during init", sel_init_viol, 0);
        check(dir_viol == 0, "R11 dir during load", dir_viol, 0);
        if (hinit) begin
            check(sel_any == 0 && ecnt == 0, "R3 no select on init timeout", sel_any, 0);
            check(cyc >= TMO, "R3 timeout latency", cyc, TMO);
        end else begin
            bad = 0;
            k = 0;
            for (int i = 0; i < n; i++) begin
                if (k < 256 && rec[k] !== bytes[i]) bad++;
                k++;
                if (en && i == st_at && st_len > 0) begin
                    for (int j = 0; j < st_len; j++) begin
                        if (k < 256 && rec[k] !== bytes[i]) bad++;
                        k++;
                    end
                end
            end
            check(ecnt == k, en ? "R5 edge count with stall" : "R4/R5 edge count", ecnt, k);
            check(bad == 0, "R4 byte order on edges", bad, 0);
            check(pre_edges == 0, "R4 no edge before wr/sel", pre_edges, 0);
            check(order_viol == 0, "R6 sel released before wr", order_viol, 0);
            if (dn_after >= 0)
                check(post_edges == dn_after, "R7 done-wait edges", post_edges, dn_after);
            else
                check(post_edges > 0, "R8 clocking during done wait", post_edges, 1);
        end
        @(posedge clk);
        load_act = 0;
        hold_init = 0;
        cfg_busy = 1'b0;
    endtask

    task automatic run_read(input int len);
        bit fl;
        int cyc;
        int bad;
        @(posedge clk);
        rcnt = 0; rd_edges = 0; xedges = 0; rd_got = 0; sel_clk_viol = 0; rd_viol = 0;
        rd_act = 1;
        @(negedge clk);
        read_len = 16'(len);
        start_read = 1'b1;
        @(negedge clk);
        start_read = 1'b0;
        wait_result(fl, cyc);
        check(fl == 0, "R10 readback op_fail", fl, 0);
        check(rd_got == len, "R9 readback byte count", rd_got, len);
        bad = 0;
        for (int i = 0; i < len && i < 64; i++)
            if (rd_buf[i] !== rd_pat(i)) bad++;
        check(bad == 0, "R9 readback data order", bad, 0);
        check(rd_edges == len, "R9 edges while selected", rd_edges, len);
        check(sel_clk_viol == 0, "R9 select with clock high", sel_clk_viol, 0);
        check(xedges == (len > 0 ? 1 : 0), "R10 trailing edge", xedges, len > 0 ? 1 : 0);
        check(rd_viol == 0, "R11 read direction", rd_viol, 0);
        @(posedge clk);
        rd_act = 0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=150000 expected=less");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin : main
        int seed_dummy;
        seed_dummy = $urandom(20240611);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cfg_clk == 1'b1, "R1 clk idles high", cfg_clk, 1);
        check({cfg_prog, cfg_sel, cfg_wr, cfg_dir} == 4'b0, "R1 control lines low",
              {cfg_prog, cfg_sel, cfg_wr, cfg_dir}, 0);
        check({in_ready, out_valid, op_done} == 3'b0, "R1 handshake low",
              {in_ready, out_valid, op_done}, 0);

        // directed corners
        run_load(1, 0, -1, 0, 0, 0, 5, 0);        // single byte, done already high
        run_load(6, 1, 2, 4, 3, 0, 20, 0);        // R5 stall on byte 2
        run_load(6, 0, 2, 4, 2, 0, 10, 0);        // R5 busy ignored when disabled
        run_load(4, 1, 3, 2, 1, 0, 0, 0);         // stall on last byte
        run_load(3, 0, -1, 0, -1, 0, 8, 1);       // R8 done never rises
        run_load(0, 0, -1, 0, 0, 1, 0, 1);        // R3 init never clears
        run_read(1);
        run_read(9);

        // constrained random loads and readbacks
        for (int t = 0; t < 6; t++) begin
            int n;
            n = 1 + int'($urandom % 20);
            run_load(n, 1'($urandom % 2), int'($urandom % n), int'($urandom % 6),
                     int'($urandom % 8), 0, int'($urandom % 50), 0);
        end
        run_read(1 + int'($urandom % 12));
        run_read(1 + int'($urandom % 12));

        check(min_phase >= HALF, "R12 clock phase width", min_phase, HALF);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule